// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of lock flags shared by two independent ports, called A and B. Software on either side claims a flag by writing 0 to it and gives it back by writing 1. A read shows whether the reading port currently holds that flag. Mutual exclusion is therefore settled in hardware, with no read-modify-write race.

A port enters the bank by raising its semaphore select while its memory chip select is low. A 3-bit index picks one of the flags. Writes look only at data bit 0. A read returns one bit of ownership, copied onto every bit of the data bus and registered for one cycle.

If a port asks for a flag that the other port holds, nothing visible changes, but the request is remembered. When the holder releases the flag, the waiting port becomes the owner in the same edge. The waiting port can cancel its request by writing 1. If both ports ask for a free flag in the same cycle, port A wins and port B is left waiting.

Top module: `sem_bank`

## Requirements
- R1: Each of the N_SEM flags (default 8) is picked by the index input and changes state independently. An access to one flag leaves every other flag unchanged, including the highest index.
- R2: A read gives 16'h0000 on the reading port's rdata the cycle after the access when that port holds the selected flag, and 16'hFFFF otherwise. Data is always all bits equal. A write looks only at wdata bit 0; the other bits have no effect.
- R3: A port reaches the bank only when its sem_sel is 1 and its mem_cs is 0. Any other combination changes no flag and leaves that port's rdata unchanged.
- R4: Writing 0 to a free flag makes the writing port its holder. Writing 0 to a flag the port already holds changes nothing.
- R5: Writing 0 to a flag held by the other port changes nothing that either port can read, but it records a pending request for the writer.
- R6: When the holder writes 1 and the other port has a pending request, the other port becomes the holder on that same clock edge.
- R7: When the holder writes 1 and no request is pending, the flag becomes free and both ports read 16'hFFFF.
- R8: Writing 1 by a port that neither holds the flag nor has a request pending on it has no effect.
- R9: When both ports write 0 to the same free flag in the same cycle, port A becomes the holder and port B's request stays pending.
- R10: A port with a pending request that writes 1 withdraws the request. A later release by the holder then frees the flag.
- R11: Synchronous reset (rst high) frees every flag, clears every pending request and sets both rdata outputs to 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_mem_cs | input | 1 | Port A memory chip select; must be 0 for bank access |
| a_sem_sel | input | 1 | Port A semaphore select |
| a_we | input | 1 | Port A write strobe (1 write, 0 read) |
| a_idx | input | IDX_W (3) | Port A flag index |
| a_wdata | input | DATA_W (16) | Port A write data, bit 0 used |
| a_rdata | output | DATA_W (16) | Port A registered read data |
| b_mem_cs | input | 1 | Port B memory chip select; must be 0 for bank access |
| b_sem_sel | input | 1 | Port B semaphore select |
| b_we | input | 1 | Port B write strobe (1 write, 0 read) |
| b_idx | input | IDX_W (3) | Port B flag index |
| b_wdata | input | DATA_W (16) | Port B write data, bit 0 used |
| b_rdata | output | DATA_W (16) | Port B registered read data |

## Verification
Ownership, whether a request is waiting, and the read value all come from the same per-flag state. A wrong holder therefore shows at the ports on the next read: one cycle after the access, the rdata word is inverted. A lost or stray pending request shows no sign until the holder releases the flag. The bench therefore releases the flag and then reads it from both sides. That exposes the fault two cycles after the release write. A fault in the index decode shows up as a neighbouring flag changing, so flags are read from the opposite port and across several indices.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'b00,
    OWN_A    = 2'b01,
    OWN_B    = 2'b10
  } owner_t;
endpackage

// File: rtl/sem_port_dec.sv
// Turns one port's strobes into per-flag claim and give-back pulses.
module sem_port_dec #(
  parameter int N_SEM  = 8,
  parameter int IDX_W  = $clog2(N_SEM),
  parameter int DATA_W = 16
) (
  input  logic              mem_cs,
  input  logic              sem_sel,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [N_SEM-1:0]  req,
  output logic [N_SEM-1:0]  rel,
  output logic              rd
);
  logic acc;
  assign acc = sem_sel && !mem_cs;
  assign rd  = acc && !we;

  for (genvar i = 0; i < N_SEM; i++) begin : g_flag
    logic hit;
    assign hit    = acc && we && (idx == IDX_W'(i));
    assign req[i] = hit && !wdata[0];
    assign rel[i] = hit &&  wdata[0];
  end
endmodule

// File: rtl/sem_cell.sv
// One lock flag: holder plus a single pending bit for the non-holder.
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_req,
  input  logic a_rel,
  input  logic b_req,
  input  logic b_rel,
  output logic hold_a,
  output logic hold_b,
  output logic pend_a,
  output logic pend_b
);
  owner_t owner_q, owner_d;
  logic   pend_q, pend_d;
  logic   wait_b, wait_a;

  always_comb begin
    owner_d = owner_q;
    pend_d  = pend_q;
    wait_b  = (pend_q || b_req) && !b_rel;
    wait_a  = (pend_q || a_req) && !a_rel;
    unique case (owner_q)
      OWN_NONE: begin
        if (a_req) begin
          owner_d = OWN_A;
          pend_d  = b_req;
        end else if (b_req) begin
          owner_d = OWN_B;
          pend_d  = 1'b0;
        end
      end
      OWN_A: begin
        if (a_rel) begin
          owner_d = wait_b ? OWN_B : OWN_NONE;
          pend_d  = 1'b0;
        end else begin
          pend_d = wait_b;
        end
      end
      OWN_B: begin
        if (b_rel) begin
          owner_d = wait_a ? OWN_A : OWN_NONE;
          pend_d  = 1'b0;
        end else begin
          pend_d = wait_a;
        end
      end
      default: begin
        owner_d = OWN_NONE;
        pend_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= OWN_NONE;
      pend_q  <= 1'b0;
    end else begin
      owner_q <= owner_d;
      pend_q  <= pend_d;
    end
  end

  assign hold_a = (owner_q == OWN_A);
  assign hold_b = (owner_q == OWN_B);
  assign pend_a = pend_q && (owner_q == OWN_B);
  assign pend_b = pend_q && (owner_q == OWN_A);
endmodule

// File: rtl/sem_read_port.sv
// Registered port-relative read: zeros when this port holds the flag.
module sem_read_port #(
  parameter int N_SEM  = 8,
  parameter int IDX_W  = $clog2(N_SEM),
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [IDX_W-1:0]  idx,
  input  logic [N_SEM-1:0]  held,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '1;
    end else if (rd) begin
      rdata <= {DATA_W{~held[idx]}};
    end
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int N_SEM  = 8,
  parameter int IDX_W  = $clog2(N_SEM),
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_mem_cs,
  input  logic              a_sem_sel,
  input  logic              a_we,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_mem_cs,
  input  logic              b_sem_sel,
  input  logic              b_we,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  logic [N_SEM-1:0] a_req, a_rel, b_req, b_rel;
  logic [N_SEM-1:0] hold_a, hold_b, pend_a, pend_b;
  logic             a_rd, b_rd;

  sem_port_dec #(.N_SEM(N_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dec_a (
    .mem_cs(a_mem_cs), .sem_sel(a_sem_sel), .we(a_we), .idx(a_idx),
    .wdata(a_wdata), .req(a_req), .rel(a_rel), .rd(a_rd)
  );

  sem_port_dec #(.N_SEM(N_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dec_b (
    .mem_cs(b_mem_cs), .sem_sel(b_sem_sel), .we(b_we), .idx(b_idx),
    .wdata(b_wdata), .req(b_req), .rel(b_rel), .rd(b_rd)
  );

  for (genvar i = 0; i < N_SEM; i++) begin : g_cell
    sem_cell u_cell (
      .clk(clk), .rst(rst),
      .a_req(a_req[i]), .a_rel(a_rel[i]),
      .b_req(b_req[i]), .b_rel(b_rel[i]),
      .hold_a(hold_a[i]), .hold_b(hold_b[i]),
      .pend_a(pend_a[i]), .pend_b(pend_b[i])
    );
  end

  sem_read_port #(.N_SEM(N_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd_a (
    .clk(clk), .rst(rst), .rd(a_rd), .idx(a_idx), .held(hold_a), .rdata(a_rdata)
  );

  sem_read_port #(.N_SEM(N_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd_b (
    .clk(clk), .rst(rst), .rd(b_rd), .idx(b_idx), .held(hold_b), .rdata(b_rdata)
  );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int N_SEM  = 8,
  parameter int IDX_W  = $clog2(N_SEM),
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              a_mem_cs,
  input logic              a_sem_sel,
  input logic              a_we,
  input logic [IDX_W-1:0]  a_idx,
  input logic [DATA_W-1:0] a_wdata,
  input logic [DATA_W-1:0] a_rdata,
  input logic              b_mem_cs,
  input logic              b_sem_sel,
  input logic              b_we,
  input logic [IDX_W-1:0]  b_idx,
  input logic [DATA_W-1:0] b_wdata,
  input logic [DATA_W-1:0] b_rdata,
  input logic [N_SEM-1:0]  hold_a,
  input logic [N_SEM-1:0]  hold_b,
  input logic [N_SEM-1:0]  pend_a,
  input logic [N_SEM-1:0]  pend_b
);
  logic a_acc, b_acc, a_wr0, a_wr1, b_wr0, same;
  logic [N_SEM-1:0] free_v;
  assign a_acc  = a_sem_sel && !a_mem_cs;
  assign b_acc  = b_sem_sel && !b_mem_cs;
  assign a_wr0  = a_acc && a_we && !a_wdata[0];
  assign a_wr1  = a_acc && a_we &&  a_wdata[0];
  assign b_wr0  = b_acc && b_we && !b_wdata[0];
  assign same   = b_acc && (b_idx == a_idx);
  assign free_v = ~(hold_a | hold_b);

  a_r4_grant: assert property (@(posedge clk) disable iff (rst)
    (a_wr0 && free_v[a_idx] && !same) |=> hold_a[$past(a_idx)]);

  a_r6_handover: assert property (@(posedge clk) disable iff (rst)
    (a_wr1 && hold_a[a_idx] && pend_b[a_idx] && !same) |=> hold_b[$past(a_idx)]);

  a_r9_left_first: assert property (@(posedge clk) disable iff (rst)
    (a_wr0 && b_wr0 && (a_idx == b_idx) && free_v[a_idx])
    |=> (hold_a[$past(a_idx)] && pend_b[$past(a_idx)]));

  a_r3_no_access_stable: assert property (@(posedge clk) disable iff (rst)
    (!a_acc && !b_acc) |=> ($stable(hold_a) && $stable(hold_b) &&
                            $stable(pend_a) && $stable(pend_b)));

  a_r2_replicated: assert property (@(posedge clk) disable iff (rst)
    (a_rdata == '0 || a_rdata == '1) && (b_rdata == '0 || b_rdata == '1));

  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> ((hold_a | hold_b | pend_a | pend_b) == '0 &&
             a_rdata == '1 && b_rdata == '1));
endmodule

bind sem_bank sem_bank_chk #(.N_SEM(N_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sem_bank_test.sv
`timescale 1ns/1ps
module sem_bank_test;
  localparam int DW = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_mem_cs = 1'b0, a_sem_sel = 1'b0, a_we = 1'b0;
  logic b_mem_cs = 1'b0, b_sem_sel = 1'b0, b_we = 1'b0;
  logic [2:0] a_idx = '0, b_idx = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sem_bank uut (
    .clk(clk), .rst(rst),
    .a_mem_cs(a_mem_cs), .a_sem_sel(a_sem_sel), .a_we(a_we), .a_idx(a_idx),
    .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_mem_cs(b_mem_cs), .b_sem_sel(b_sem_sel), .b_we(b_we), .b_idx(b_idx),
    .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  // op: 0 idle, 1 read, 2 write. Fields: aop aidx ad bop bidx bd ea eb req.
  function automatic logic [17:0] v(int ao, int ai, int ad, int bo, int bi,
                                    int bd, int ea, int eb, int rq);
    return {ao[1:0], ai[2:0], ad[0], bo[1:0], bi[2:0], bd[0], ea[0], eb[0], rq[3:0]};
  endfunction

  localparam int NV = 25;
  localparam logic [17:0] VEC [NV] = '{
    v(1,0,0, 1,0,0, 1,1, 11), // R11 free after reset
    v(2,0,0, 0,0,0, 0,0, 4),
    v(1,0,0, 1,0,0, 0,1, 4),  // R4 A holds flag 0
    v(0,0,0, 2,0,0, 0,0, 5),
    v(1,0,0, 1,0,0, 0,1, 5),  // R5 no visible change
    v(2,0,1, 0,0,0, 0,0, 6),
    v(1,0,0, 1,0,0, 1,0, 6),  // R6 B takes over
    v(2,0,1, 0,0,0, 0,0, 8),
    v(1,0,0, 1,0,0, 1,0, 8),  // R8 stray release ignored
    v(0,0,0, 2,0,1, 0,0, 7),
    v(1,0,0, 1,0,0, 1,1, 7),  // R7 free again
    v(2,1,0, 2,1,0, 0,0, 9),
    v(1,1,0, 1,1,0, 0,1, 9),  // R9 A wins tie
    v(2,1,1, 0,0,0, 0,0, 9),
    v(1,1,0, 1,1,0, 1,0, 9),  // R9 B was left pending
    v(0,0,0, 2,1,1, 0,0, 7),
    v(2,2,0, 2,3,0, 0,0, 1),
    v(1,2,0, 1,3,0, 0,0, 1),  // R1 independent flags
    v(1,3,0, 1,2,0, 1,1, 1),  // R1 cross reads
    v(2,3,0, 0,0,0, 0,0, 10),
    v(2,3,1, 0,0,0, 0,0, 10),
    v(0,0,0, 2,3,1, 0,0, 10),
    v(1,3,0, 1,3,0, 1,1, 10), // R10 withdrawn request
    v(2,7,0, 0,0,0, 0,0, 1),
    v(1,7,0, 1,7,0, 0,1, 1)   // R1 top index
  };

  task automatic chk(input int rq, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL R%0d %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic set_a(input int op, input int idx, input int d, input logic cs);
    a_mem_cs  = cs;
    a_sem_sel = (op != 0);
    a_we      = (op == 2);
    a_idx     = idx[2:0];
    a_wdata   = {15'h2D4B, d[0]};
  endtask

  task automatic set_b(input int op, input int idx, input int d, input logic cs);
    b_mem_cs  = cs;
    b_sem_sel = (op != 0);
    b_we      = (op == 2);
    b_idx     = idx[2:0];
    b_wdata   = {15'h52B4, d[0]};
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R11 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(11, "a_rdata after reset", a_rdata, '1);
    chk(11, "b_rdata after reset", b_rdata, '1);

    for (int k = 0; k < NV; k++) begin
      logic [17:0] e;
      e = VEC[k];
      set_a(int'(e[17:16]), int'(e[15:13]), int'(e[12]), 1'b0);
      set_b(int'(e[11:10]), int'(e[9:7]), int'(e[6]), 1'b0);
      step();
      if (e[17:16] == 2'd1) chk(int'(e[3:0]), "a_rdata", a_rdata, {DW{e[5]}});
      if (e[11:10] == 2'd1) chk(int'(e[3:0]), "b_rdata", b_rdata, {DW{e[4]}});
    end
    set_a(0, 0, 0, 1'b0);
    set_b(0, 0, 0, 1'b0);

    // R3: claims with mem_cs high, or with select low, are ignored
    set_a(2, 4, 0, 1'b1); step();
    set_a(0, 5, 0, 1'b0); a_we = 1'b1; step();
    set_a(1, 4, 0, 1'b0); set_b(1, 4, 0, 1'b0); step();
    chk(3, "a_rdata idx4 after gated write", a_rdata, '1);
    chk(3, "b_rdata idx4 after gated write", b_rdata, '1);
    set_b(0, 0, 0, 1'b0);
    set_a(1, 5, 0, 1'b0); step();
    chk(3, "a_rdata idx5 after deselected write", a_rdata, '1);
    // R3: a read with mem_cs high must not update rdata
    set_a(1, 7, 0, 1'b0); step();
    chk(1, "a_rdata idx7 held", a_rdata, '0);
    set_a(1, 0, 0, 1'b1); step();
    chk(3, "a_rdata kept under mem_cs", a_rdata, '0);
    set_a(0, 0, 0, 1'b0);

    // R11: reset mid-run clears holder and pending request
    set_b(2, 7, 0, 1'b0); step();
    set_b(0, 0, 0, 1'b0);
    rst = 1'b1; step(); step();
    rst = 1'b0;
    chk(11, "a_rdata reset value", a_rdata, '1);
    set_a(1, 7, 0, 1'b0); set_b(1, 7, 0, 1'b0); step();
    chk(11, "a_rdata idx7 after reset", a_rdata, '1);
    chk(11, "b_rdata idx7 after reset", b_rdata, '1);
    set_a(2, 7, 0, 1'b0); set_b(0, 0, 0, 1'b0); step();
    set_a(2, 7, 1, 1'b0); step();
    set_a(1, 7, 0, 1'b0); set_b(1, 7, 0, 1'b0); step();
    chk(11, "b_rdata no stale request", b_rdata, '1);
    chk(7, "a_rdata released", a_rdata, '1);

    // R2: upper write bits ignored; a write of 16'hFFFE claims
    set_b(2, 6, 0, 1'b0); set_a(0, 0, 0, 1'b0); b_wdata = 16'hFFFE; step();
    set_b(1, 6, 0, 1'b0); set_a(1, 6, 0, 1'b0); step();
    chk(2, "b_rdata claim via bit0", b_rdata, '0);
    chk(2, "a_rdata other side", a_rdata, '1);
    set_a(0, 0, 0, 1'b0); set_b(0, 0, 0, 1'b0);
    step();
    finish_run();
  end
endmodule